// File: doc/BRIEF.md
# SD Command Response Evaluator

This block sits between the host-facing register set of an SD/MMC host controller and the part that talks to the card. When the host issues a command word, the block captures it together with the card's reply. The reply comes as a buffer of up to sixteen bytes plus a count of how many bytes actually arrived. The block decides which kind of reply the command expects and whether the reply was long enough. It then checks the card status carried in the reply for error flags and fills eight 16-bit response registers. Finally it raises completion, timeout, stop, card-error and not-ready bits in a sticky 16-bit status word.

A command whose type marks it as an addressed data transfer also arms the data path. The block raises a transfer-active flag, latches the transfer direction and gives a one-cycle FIFO pointer reset pulse. The host clears status bits by writing a mask in which each 1 clears the matching bit. A command is accepted only while the controller is enabled and no earlier command is still being evaluated. Evaluation takes two clock edges: the first captures the inputs and clears the registers, the second applies the results.

Top module: `sd_rsp_eval`

## Requirements
- R1: A start strobe is accepted only when `ctrl_en` is 1 and no evaluation is in progress. A strobe with `ctrl_en` 0 leaves the response registers, the status word, `xfer_active`, `xfer_dir` and `fifo_reset` unchanged.
- R2: At the clock edge that accepts a command, all eight response registers become zero. The results of that command appear after the next clock edge.
- R3: A command word with bit 7 (initialisation) set and bits 5:0 equal to 0 sets only status bit 0. Its response registers stay zero and the transfer controls keep their previous values.
- R4: Bits 10:8 select the reply kind. Codes 1, 3 and 6 need at least 4 bytes and code 2 needs 16 (`rsp_len` compared unsigned). A shorter reply sets status bit 7 instead of bit 0 and leaves the response registers zero.
- R5: For code 1, bytes 0..3 form a big-endian 32-bit word. Any of its bits under mask 0xFDF90000 sets status bit 14. Bit 3 counts as an error only when `sdio_ake_en` is 1. Bit 11 of the command word (busy) does not change this result.
- R6: For code 6, only bytes 2 (high) and 3 (low) are checked, as a 16-bit word against mask 0xE008. Any bit set under that mask sets status bit 14.
- R7: For code 3, when bit 7 of byte 0 (bit 31 of the big-endian word) is 0, status bit 12 is set.
- R8: When a reply of code 1, 2, 3 or 6 meets its minimum length, the registers are loaded from all sixteen buffered bytes. Register 7-i (bits 16(7-i)+15 : 16(7-i) of `rsp_regs`) holds byte 2i in its high half and byte 2i+1 in its low half. Byte k of `rsp_bytes` is bits 8k+7:8k.
- R9: A completed command with index 12 sets status bits 0 and 2, and any other completed command sets bit 0 only. Codes 0, 4, 5 and 7 complete without a length check, an error check or a register load.
- R10: Command type bits 13:12 equal to 3 set `xfer_active`, latch `xfer_dir` from bit 15 and pulse `fifo_reset` for exactly one cycle with the result. Any other type clears `xfer_active`.
- R11: A `stat_clr` strobe clears every status bit set in `stat_clr_mask`. A bit that evaluation sets in the same cycle stays set. Only bits 0, 2, 7, 12 and 14 can ever be 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; commands are ignored while low |
| cmd_word | input | 16 | Command word written by the host |
| cmd_start | input | 1 | Strobe: evaluate `cmd_word` with the current reply inputs |
| sdio_ake_en | input | 1 | Treat card-status bit 3 as an error for code-1 replies |
| rsp_bytes | input | 128 | Reply buffer, byte k at bits 8k+7:8k |
| rsp_len | input | 5 | Number of valid reply bytes |
| stat_clr_mask | input | 16 | Status bits to clear |
| stat_clr | input | 1 | Strobe applying `stat_clr_mask` |
| rsp_regs | output | 128 | Eight response registers, register n at bits 16n+15:16n |
| status | output | 16 | Sticky status word |
| xfer_active | output | 1 | Data transfer armed |
| xfer_dir | output | 1 | Latched direction of the armed transfer |
| fifo_reset | output | 1 | One-cycle FIFO pointer reset pulse |

## Verification
Directed commands cover each reply code at, just below and above its minimum length, which separates the timeout path from the completion path. Card-status words carry single error flags, non-error bits and the gated bit 3 with the gate both on and off, which shows whether the right error mask is used for each code. Index 12 and other indices separate the stop bit, and data-transfer and non-transfer types in both directions separate arming from disarming. Randomised commands with random bytes, lengths and status clears, including clears that land on the evaluation edge, compare every output after every command against a model built from the requirements.

// File: rtl/sd_rsp_pkg.sv
// Package: shared constants and types of the SD command response evaluator.
// Assumes a 16-bit command word and a reply buffer of up to 16 bytes.
package sd_rsp_pkg;

    localparam int CMD_W      = 16;
    localparam int RSP_BYTES  = 16;
    localparam int REG_W      = 16;
    localparam int RSP_REGS   = RSP_BYTES * 8 / REG_W;
    localparam int LEN_W      = $clog2(RSP_BYTES + 1);
    localparam int STAT_W     = 16;
    localparam int SHORT_LEN  = 4;

    // Card-status error flags checked for a code-1 reply
    localparam logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000;
    // Authentication sequence error flag, gated by the SDIO control bit
    localparam logic [31:0] AKE_FLAG      = 32'h0000_0008;
    // Error mask for the 16-bit address-publish reply (code 6)
    localparam logic [15:0] ADDR_ERR_MASK = 16'hE008;

    // Status bit positions owned by this block
    localparam int ST_DONE = 0;
    localparam int ST_STOP = 2;
    localparam int ST_TMO  = 7;
    localparam int ST_NRDY = 12;
    localparam int ST_CERR = 14;

    localparam logic [1:0] CT_DATA  = 2'd3;
    localparam logic [5:0] STOP_IDX = 6'd12;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_STATB,
        RK_LONG,
        RK_OCR,
        RK_ADDR,
        RK_OTHER
    } rsp_kind_e;

    typedef enum logic {
        PH_IDLE,
        PH_EVAL
    } phase_e;

    typedef struct packed {
        rsp_kind_e  kind;
        logic [1:0] ctype;
        logic       dir;
        logic       init_only;
        logic       is_stop;
    } cmd_dec_t;

    typedef struct packed {
        logic timeout;
        logic card_err;
        logic not_ready;
        logic load;
    } judge_t;

endpackage

// File: rtl/sd_cmd_decode.sv
// Module: splits a captured command word into the fields the evaluator uses.
// Assumes the word is stable for the evaluation cycle; purely combinational.
module sd_cmd_decode
    import sd_rsp_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_word,
    output cmd_dec_t         dec
);

    logic unused_bits;
    assign unused_bits = ^{cmd_word[14], cmd_word[6]};

    // Map the reply code and busy flag to a reply kind and extract flags
    always_comb begin
        dec = '0;
        case (cmd_word[10:8])
            3'd0:    dec.kind = RK_NONE;
            3'd1:    dec.kind = cmd_word[11] ? RK_STATB : RK_STAT;
            3'd2:    dec.kind = RK_LONG;
            3'd3:    dec.kind = RK_OCR;
            3'd6:    dec.kind = RK_ADDR;
            default: dec.kind = RK_OTHER;
        endcase
        dec.ctype     = cmd_word[13:12];
        dec.dir       = cmd_word[15];
        dec.init_only = cmd_word[7] && (cmd_word[5:0] == 6'd0);
        dec.is_stop   = (cmd_word[5:0] == STOP_IDX);
    end

endmodule

// File: rtl/sd_rsp_judge.sv
// Module: judges a card reply: length against the kind's minimum, error flags,
// and the busy flag of an operating-condition reply. Combinational.
// Assumes head holds reply bytes 0..3 with byte 0 in the top eight bits.
module sd_rsp_judge
    import sd_rsp_pkg::*;
(
    input  rsp_kind_e        kind,
    input  logic [31:0]      head,
    input  logic [LEN_W-1:0] len,
    input  logic             ake_en,
    output judge_t           res
);

    logic [LEN_W-1:0] need;
    logic             has_rsp;
    logic             too_short;
    logic [31:0]      stat_mask;

    // Minimum byte count for the reply kind
    always_comb begin
        need = (kind == RK_LONG) ? LEN_W'(RSP_BYTES) : LEN_W'(SHORT_LEN);
    end

    // Decide whether the kind carries a reply at all
    always_comb begin
        case (kind)
            RK_STAT, RK_STATB, RK_LONG, RK_OCR, RK_ADDR: has_rsp = 1'b1;
            default:                                    has_rsp = 1'b0;
        endcase
    end

    assign too_short = has_rsp && (len < need);
    assign stat_mask = CARD_ERR_MASK | (ake_en ? AKE_FLAG : 32'h0);

    // Form the verdict for the evaluation cycle
    always_comb begin
        res         = '0;
        res.timeout = too_short;
        res.load    = has_rsp && !too_short;
        if (!too_short) begin
            case (kind)
                RK_STAT, RK_STATB: res.card_err  = |(head & stat_mask);
                RK_ADDR:           res.card_err  = |(head[15:0] & ADDR_ERR_MASK);
                RK_OCR:            res.not_ready = !head[31];
                default:           res.card_err  = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sd_rsp_bank.sv
// Module: the response register bank. Cleared when a command is accepted,
// loaded from the reply buffer in reversed pairs when a reply is valid.
// Assumes clear and load never coincide (they belong to different phases).
module sd_rsp_bank
    import sd_rsp_pkg::*;
#(
    parameter int NREG = RSP_REGS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  load,
    input  logic [NREG*2*8-1:0]   bytes,
    output logic [NREG*REG_W-1:0] regs
);

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam int PAIR = NREG - 1 - k;
        logic [REG_W-1:0] word_q;

        // Hold one response register
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                word_q <= '0;
            end else if (load) begin
                word_q <= {bytes[16*PAIR +: 8], bytes[16*PAIR+8 +: 8]};
            end
        end

        assign regs[REG_W*k +: REG_W] = word_q;
    end

endmodule

// File: rtl/sd_rsp_eval.sv
// Module: top of the SD command response evaluator. Accepts a command with
// its reply, evaluates it over two edges and updates the response registers,
// the sticky status word and the data-transfer start controls.
// Assumes the reply inputs are valid in the cycle of the start strobe.
module sd_rsp_eval
    import sd_rsp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctrl_en,
    input  logic [CMD_W-1:0]           cmd_word,
    input  logic                       cmd_start,
    input  logic                       sdio_ake_en,
    input  logic [RSP_BYTES*8-1:0]     rsp_bytes,
    input  logic [LEN_W-1:0]           rsp_len,
    input  logic [STAT_W-1:0]          stat_clr_mask,
    input  logic                       stat_clr,
    output logic [RSP_REGS*REG_W-1:0]  rsp_regs,
    output logic [STAT_W-1:0]          status,
    output logic                       xfer_active,
    output logic                       xfer_dir,
    output logic                       fifo_reset
);

    phase_e                  phase;
    logic                    in_eval;
    logic                    accept;
    logic [CMD_W-1:0]        cmd_q;
    logic [RSP_BYTES*8-1:0]  bytes_q;
    logic [LEN_W-1:0]        len_q;
    logic                    ake_q;
    cmd_dec_t                dec;
    judge_t                  verdict;
    logic [STAT_W-1:0]       set_vec;
    logic [STAT_W-1:0]       clr_vec;
    logic [STAT_W-1:0]       stat_q;
    logic                    xa_q;
    logic                    xd_q;
    logic                    fr_q;

    assign in_eval = (phase == PH_EVAL);
    assign accept  = cmd_start && ctrl_en && !in_eval;

    // Two-step sequencer: capture, then apply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (accept) begin
            phase <= PH_EVAL;
        end else begin
            phase <= PH_IDLE;
        end
    end

    // Capture the command and the reply at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            bytes_q <= '0;
            len_q   <= '0;
            ake_q   <= 1'b0;
        end else if (accept) begin
            cmd_q   <= cmd_word;
            bytes_q <= rsp_bytes;
            len_q   <= rsp_len;
            ake_q   <= sdio_ake_en;
        end
    end

    sd_cmd_decode u_decode (
        .cmd_word (cmd_q),
        .dec      (dec)
    );

    sd_rsp_judge u_judge (
        .kind   (dec.kind),
        .head   ({bytes_q[7:0], bytes_q[15:8], bytes_q[23:16], bytes_q[31:24]}),
        .len    (len_q),
        .ake_en (ake_q),
        .res    (verdict)
    );

    sd_rsp_bank #(
        .NREG (RSP_REGS)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .load  (in_eval && verdict.load && !dec.init_only),
        .bytes (bytes_q),
        .regs  (rsp_regs)
    );

    // Status bits raised by the evaluation cycle
    always_comb begin
        set_vec = '0;
        if (in_eval) begin
            if (dec.init_only) begin
                set_vec[ST_DONE] = 1'b1;
            end else if (verdict.timeout) begin
                set_vec[ST_TMO] = 1'b1;
            end else begin
                set_vec[ST_DONE] = 1'b1;
                set_vec[ST_STOP] = dec.is_stop;
                set_vec[ST_CERR] = verdict.card_err;
                set_vec[ST_NRDY] = verdict.not_ready;
            end
        end
    end

    assign clr_vec = stat_clr ? stat_clr_mask : '0;

    // Sticky status word: host clears, evaluation sets, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    // Data-transfer start controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xa_q <= 1'b0;
            xd_q <= 1'b0;
            fr_q <= 1'b0;
        end else begin
            fr_q <= 1'b0;
            if (in_eval && !dec.init_only) begin
                if (dec.ctype == CT_DATA) begin
                    xa_q <= 1'b1;
                    xd_q <= dec.dir;
                    fr_q <= 1'b1;
                end else begin
                    xa_q <= 1'b0;
                end
            end
        end
    end

    assign status      = stat_q;
    assign xfer_active = xa_q;
    assign xfer_dir    = xd_q;
    assign fifo_reset  = fr_q;

endmodule

// File: rtl/sd_rsp_eval_chk.sv
// Module: assertion checker for sd_rsp_eval, attached by bind below.
// Assumes the evaluation phase flag of the top is visible as in_eval.
module sd_rsp_eval_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         ctrl_en,
    input logic         cmd_start,
    input logic         stat_clr,
    input logic [15:0]  stat_clr_mask,
    input logic [127:0] rsp_regs,
    input logic [15:0]  status,
    input logic         xfer_active,
    input logic         fifo_reset,
    input logic         in_eval
);

    AST_OFF_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && cmd_start && !in_eval) |=> ($stable(rsp_regs) && $stable(xfer_active) && !in_eval)); // R1

    AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && cmd_start && !in_eval) |=> (in_eval && rsp_regs == 128'h0)); // R2

    AST_TMO_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[7]) |-> (rsp_regs == 128'h0)); // R4

    AST_STOP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> status[0]); // R9

    AST_FIFO_WITH_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_reset |-> xfer_active); // R10

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !in_eval) |=> ((status & $past(stat_clr_mask)) == 16'h0)); // R11

    AST_SET_FROM_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) != 16'h0) |-> $past(in_eval)); // R11

    AST_OWNED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~16'h5085) == 16'h0); // R11

endmodule

bind sd_rsp_eval sd_rsp_eval_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_en       (ctrl_en),
    .cmd_start     (cmd_start),
    .stat_clr      (stat_clr),
    .stat_clr_mask (stat_clr_mask),
    .rsp_regs      (rsp_regs),
    .status        (status),
    .xfer_active   (xfer_active),
    .fifo_reset    (fifo_reset),
    .in_eval       (in_eval)
);

// File: tb/sd_rsp_eval_tb.sv
// Bench: directed corner cases plus seeded random commands, checked against
// a requirement-level model kept in this file.
module sd_rsp_eval_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ctrl_en;
    logic [15:0]  cmd_word;
    logic         cmd_start;
    logic         sdio_ake_en;
    logic [127:0] rsp_bytes;
    logic [4:0]   rsp_len;
    logic [15:0]  stat_clr_mask;
    logic         stat_clr;
    logic [127:0] rsp_regs;
    logic [15:0]  status;
    logic         xfer_active;
    logic         xfer_dir;
    logic         fifo_reset;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0]  m_stat = '0;
    logic [127:0] m_regs = '0;
    logic         m_xa = 1'b0;
    logic         m_xd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_rsp_eval dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_en       (ctrl_en),
        .cmd_word      (cmd_word),
        .cmd_start     (cmd_start),
        .sdio_ake_en   (sdio_ake_en),
        .rsp_bytes     (rsp_bytes),
        .rsp_len       (rsp_len),
        .stat_clr_mask (stat_clr_mask),
        .stat_clr      (stat_clr),
        .rsp_regs      (rsp_regs),
        .status        (status),
        .xfer_active   (xfer_active),
        .xfer_dir      (xfer_dir),
        .fifo_reset    (fifo_reset)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reply buffer with a 32-bit word big-endian in bytes 0..3
    function automatic logic [127:0] mk_bytes(input logic [31:0] w, input logic [95:0] rest);
        return {rest, w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // Expected register image: byte j lands in register 7 - j/2
    function automatic logic [127:0] exp_image(input logic [127:0] b);
        logic [127:0] img = '0;
        for (int j = 0; j < 16; j++) begin
            int r = 7 - j / 2;
            if (j % 2 == 0) img[16*r+8 +: 8] = b[8*j +: 8];
            else            img[16*r   +: 8] = b[8*j +: 8];
        end
        return img;
    endfunction

    // Requirement model of one accepted command
    task automatic model_cmd(input logic [15:0] cw, input logic [127:0] b,
                             input logic [4:0] ln, input logic ake,
                             input logic [15:0] clr, output logic fr);
        logic [15:0] sets = '0;
        logic [31:0] w = {b[7:0], b[15:8], b[23:16], b[31:24]};
        logic [2:0]  code = cw[10:8];
        logic        known = (code == 1) || (code == 2) || (code == 3) || (code == 6);
        int          need = (code == 2) ? 16 : 4;
        fr = 1'b0;
        m_regs = '0;
        if (cw[7] && cw[5:0] == 0) begin
            sets[0] = 1'b1;
        end else begin
            if (known && ln < need) begin
                sets[7] = 1'b1;
            end else begin
                sets[0] = 1'b1;
                if (cw[5:0] == 12) sets[2] = 1'b1;
                if (code == 1 && ((w & 32'hFDF90000) != 0 || (ake && w[3]))) sets[14] = 1'b1;
                if (code == 6 && (w[15:0] & 16'hE008) != 0) sets[14] = 1'b1;
                if (code == 3 && !w[31]) sets[12] = 1'b1;
                if (known) m_regs = exp_image(b);
            end
            if (cw[13:12] == 2'd3) begin
                m_xa = 1'b1;
                m_xd = cw[15];
                fr   = 1'b1;
            end else begin
                m_xa = 1'b0;
            end
        end
        m_stat = (m_stat & ~clr) | sets;
    endtask

    task automatic run_cmd(input string req, input logic [15:0] cw, input logic [127:0] b,
                           input logic [4:0] ln, input logic ake, input logic [15:0] clr);
        logic fr;
        @(negedge clk);
        cmd_word    = cw;
        rsp_bytes   = b;
        rsp_len     = ln;
        sdio_ake_en = ake;
        cmd_start   = 1'b1;
        @(negedge clk);
        cmd_start     = 1'b0;
        rsp_bytes     = ~b;
        rsp_len       = ~ln;
        stat_clr      = (clr != 0);
        stat_clr_mask = clr;
        if (ctrl_en) chk({req, " R2"}, "regs cleared on accept", rsp_regs, 128'h0);
        @(negedge clk);
        stat_clr = 1'b0;
        if (ctrl_en) begin
            model_cmd(cw, b, ln, ake, clr, fr);
        end else begin
            fr = 1'b0;
            m_stat = m_stat & ~clr;
        end
        chk(req, "status", 128'(status), 128'(m_stat));
        chk(req, "rsp_regs", rsp_regs, m_regs);
        chk(req, "xfer_active", 128'(xfer_active), 128'(m_xa));
        chk(req, "xfer_dir", 128'(xfer_dir), 128'(m_xd));
        chk(req, "fifo_reset", 128'(fifo_reset), 128'(fr));
        @(negedge clk);
        chk({req, " R10"}, "fifo_reset one cycle", 128'(fifo_reset), 128'h0);
    endtask

    task automatic do_clear(input logic [15:0] mask);
        @(negedge clk);
        stat_clr      = 1'b1;
        stat_clr_mask = mask;
        @(negedge clk);
        stat_clr = 1'b0;
        m_stat   = m_stat & ~mask;
        chk("R11", "status after clear", 128'(status), 128'(m_stat));
    endtask

    // Command word: dir, type, busy, code, init, index
    function automatic logic [15:0] cw_of(input logic dir, input logic [1:0] ct,
                                          input logic busy, input logic [2:0] code,
                                          input logic init, input logic [5:0] idx);
        return {dir, 1'b0, ct, busy, code, init, 1'b0, idx};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [95:0] pat;
        void'($urandom(32'h1234_5EED));
        rst_n = 1'b0; ctrl_en = 1'b0; cmd_word = '0; cmd_start = 1'b0;
        sdio_ake_en = 1'b0; rsp_bytes = '0; rsp_len = '0;
        stat_clr_mask = '0; stat_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "reset status", 128'(status), 128'h0);
        chk("R2", "reset regs", rsp_regs, 128'h0);
        chk("R10", "reset xfer", {xfer_active, xfer_dir, fifo_reset}, 128'h0);

        pat = 96'h0F1E_2D3C_4B5A_6978_8796_A5B4;
        // R1: disabled controller ignores a data command
        run_cmd("R1", cw_of(1, 3, 0, 1, 0, 17), mk_bytes(32'h0000_0900, pat), 16, 0, 0);
        ctrl_en = 1'b1;
        // R3: init with index 0
        run_cmd("R3", cw_of(0, 3, 0, 1, 1, 0), mk_bytes(32'hFFFF_FFFF, pat), 16, 0, 0);
        do_clear(16'hFFFF);
        // R8 / R9: clean code-1 reply, data read
        run_cmd("R8", cw_of(1, 3, 0, 1, 0, 17), mk_bytes(32'h0000_0900, pat), 4, 0, 0);
        run_cmd("R9", cw_of(0, 0, 1, 1, 0, 12), mk_bytes(32'h0000_0000, pat), 4, 0, 0);
        do_clear(16'hFFFF);
        // R4: short replies and boundary lengths
        run_cmd("R4", cw_of(0, 2, 0, 1, 0, 13), mk_bytes(32'h1234_5678, pat), 3, 0, 0);
        run_cmd("R4", cw_of(0, 2, 0, 2, 0, 2), mk_bytes(32'h1234_5678, pat), 15, 0, 0);
        run_cmd("R4", cw_of(0, 2, 0, 2, 0, 2), mk_bytes(32'h1234_5678, pat), 16, 0, 0);
        do_clear(16'hFFFF);
        // R5: single error flags, gated bit 3, non-error bits
        run_cmd("R5", cw_of(0, 2, 0, 1, 0, 7), mk_bytes(32'h0001_0000, pat), 4, 0, 0);
        do_clear(16'hFFFF);
        run_cmd("R5", cw_of(0, 2, 0, 1, 0, 7), mk_bytes(32'h0206_0FF7, pat), 4, 0, 0);
        run_cmd("R5", cw_of(0, 2, 0, 1, 0, 7), mk_bytes(32'h0000_0008, pat), 4, 0, 0);
        run_cmd("R5", cw_of(0, 2, 1, 1, 0, 7), mk_bytes(32'h0000_0008, pat), 4, 1, 0);
        do_clear(16'hFFFF);
        // R6: address reply, only low half checked
        run_cmd("R6", cw_of(0, 1, 0, 6, 0, 3), mk_bytes(32'hFFFF_1FF7, pat), 4, 0, 0);
        run_cmd("R6", cw_of(0, 1, 0, 6, 0, 3), mk_bytes(32'h0000_2000, pat), 4, 0, 0);
        do_clear(16'hFFFF);
        // R7: operating-condition reply busy flag
        run_cmd("R7", cw_of(0, 1, 0, 3, 0, 41), mk_bytes(32'h80FF_8000, pat), 4, 0, 0);
        run_cmd("R7", cw_of(0, 1, 0, 3, 0, 41), mk_bytes(32'h00FF_8000, pat), 4, 0, 0);
        // R9: unknown reply code completes without load
        run_cmd("R9", cw_of(0, 1, 0, 5, 0, 9), mk_bytes(32'hFFFF_FFFF, pat), 0, 0, 0);
        // R10: write-direction data command, then a non-data command
        run_cmd("R10", cw_of(0, 3, 0, 1, 0, 24), mk_bytes(32'h0, pat), 4, 0, 0);
        run_cmd("R10", cw_of(1, 2, 0, 1, 0, 13), mk_bytes(32'h0, pat), 4, 0, 0);
        // R11: clear landing on the evaluation edge
        run_cmd("R11", cw_of(0, 0, 0, 0, 0, 5), mk_bytes(32'h0, pat), 0, 0, 16'hFFFF);

        for (int i = 0; i < 400; i++) begin
            logic [15:0]  cw  = 16'($urandom);
            logic [127:0] b   = {$urandom, $urandom, $urandom, $urandom};
            logic [4:0]   ln  = 5'($urandom_range(0, 17));
            logic [15:0]  clr = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            if ($urandom_range(0, 1) == 0) b[31:0] = {b[31:28] & 4'h0, 28'h0} | 32'(b[7:0] & 8'h18);
            if ($urandom_range(0, 3) == 0) cw[10:8] = 3'd6;
            ctrl_en = ($urandom_range(0, 9) != 0);
            run_cmd("R9", cw, b, ln, 1'($urandom), clr);
            if ($urandom_range(0, 4) == 0) do_clear(16'($urandom));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule